// File: doc/BRIEF.md
# Prefix Operand Widening Unit

This block lets a narrow instruction word carry a 16-bit operand. A prefix instruction writes a byte into a held extension register and raises a one-shot extension flag. The instruction that executes next takes that byte as its upper half. The lower half comes from its own 8-bit field. The result serves as a 16-bit index load or add value, a compare value, or a signed relative branch offset. The block also holds the adder that turns the program counter and the selected offset into a branch target.

Each instruction the sequencer retires is announced with a valid strobe, a class code, the 8-bit field and the instruction's program counter. The widened operand and the branch target follow combinationally from these inputs and the held state. The flag is consumed by the next retired instruction of any class. Instruction decoding stays with the sequencer; this block only receives the class code.

Top module: `ext_addr_unit`

## Requirements
- R1: After reset the extension flag is 0 and the held extension byte is 00h.
- R2: A prefix load strobe stores its byte in the extension register, and from the next cycle the extension flag reads 1.
- R3: Class 1 (index low-byte load) yields {extension byte, field} while the flag is set, and {00h, field} otherwise. Example: 15h with 7Dh gives 157Dh.
- R4: Class 2 (index add) yields {extension byte, field} while the flag is set, and the field sign-extended to 16 bits otherwise.
- R5: Class 3 (index compare) yields {FFh minus extension byte, field} while the flag is set, and {00h, field} otherwise. Example: E6h with A2h gives 19A2h.
- R6: Class 4 (relative branch) with the flag clear gives target = pc + 1 + field sign-extended, modulo 2^16.
- R7: Class 4 with the flag set gives target = pc + 1 + {extension byte, field} taken as a signed 16-bit offset, modulo 2^16.
- R8: Class 5 (branch on register A) gives target = pc + 1 + field[3:0], between pc+1 and pc+16. The flag and the extension byte have no effect on it.
- R9: Any retired instruction with no prefix strobe in the same cycle clears the flag in the following cycle.
- R10: The flag-set strobe raises the flag and leaves the held extension byte unchanged.
- R11: The wide output is 1 only when the flag is set and the class is 1 to 4. Classes 0, 6 and 7 give {00h, field} as the operand. Every non-branch class gives pc + 1 as the target.
- R12: In cycles with no retired instruction and no strobe, the flag and the extension byte hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pfx_load_i | input | 1 | Prefix strobe: write extension byte and set flag |
| pfx_byte_i | input | 8 | Byte for the extension register |
| pfx_set_i | input | 1 | Set the flag without writing the byte |
| ins_valid_i | input | 1 | An instruction retires this cycle |
| ins_class_i | input | 3 | Instruction class code |
| ins_field_i | input | 8 | 8-bit operand field of the instruction |
| pc_i | input | 16 | Address of the retiring instruction |
| opnd_o | output | 16 | Effective operand or branch offset |
| target_o | output | 16 | Branch target, or pc + 1 for non-branch classes |
| wide_o | output | 1 | The operand was widened by the extension byte |
| ext_flag_o | output | 1 | Current extension flag |

## Verification
The assertions assume a prefix strobe never coincides with a retired instruction. A prefix is itself an instruction slot, so the sequencer never announces both in one cycle. Each bench task drives at most one of pfx_load_i, pfx_set_i and ins_valid_i per cycle and keeps every other strobe low. The bench settles each input pattern half a cycle before the clock edge. It reads the combinational outputs before that edge, so the flag a check observes is always the one left by the previous cycle.

// File: rtl/ext_pkg.sv
package ext_pkg;
  localparam int CLASS_W = 3;

  typedef enum logic [CLASS_W-1:0] {
    CLS_NONE     = 3'd0,
    CLS_IDX_LOAD = 3'd1,
    CLS_IDX_ADD  = 3'd2,
    CLS_IDX_CMP  = 3'd3,
    CLS_BR_REL   = 3'd4,
    CLS_BR_A     = 3'd5
  } ins_class_e;

  function automatic logic class_is_branch(input logic [CLASS_W-1:0] c);
    return (c == CLS_BR_REL) || (c == CLS_BR_A);
  endfunction
endpackage

// File: rtl/ext_state.sv
module ext_state #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              set_i,
  input  logic              consume_i,
  output logic              flag_o,
  output logic [BYTE_W-1:0] ext_o
);
  logic              flag_q, flag_d;
  logic [BYTE_W-1:0] ext_q, ext_d;

  always_comb begin
    flag_d = flag_q;
    ext_d  = ext_q;
    if (load_i) begin
      ext_d  = byte_i;
      flag_d = 1'b1;
    end else if (set_i) begin
      flag_d = 1'b1;
    end else if (consume_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ext_q  <= '0;
    end else begin
      flag_q <= flag_d;
      ext_q  <= ext_d;
    end
  end

  assign flag_o = flag_q;
  assign ext_o  = ext_q;

  p_load_sets_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (flag_q && ext_q == $past(byte_i)));

  p_consume_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !load_i && !set_i) |=> !flag_q);

  p_set_keeps_byte_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !load_i) |=> (flag_q && $stable(ext_q)));

  p_idle_holds_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !set_i && !consume_i) |=> ($stable(flag_q) && $stable(ext_q)));
endmodule

// File: rtl/ext_widen.sv
module ext_widen
  import ext_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic [CLASS_W-1:0] class_i,
  input  logic               flag_i,
  input  logic [BYTE_W-1:0]  ext_i,
  input  logic [BYTE_W-1:0]  field_i,
  output logic [WORD_W-1:0]  opnd_o,
  output logic               wide_o
);
  logic [WORD_W-1:0] zext_w, sext_w, ext_w, inv_w, nib_w;

  assign zext_w = {{BYTE_W{1'b0}}, field_i};
  assign sext_w = {{BYTE_W{field_i[BYTE_W-1]}}, field_i};
  assign ext_w  = {ext_i, field_i};
  // compare path: all-ones minus the stored byte
  assign inv_w  = {~ext_i, field_i};
  assign nib_w  = {{(WORD_W-NIB_W){1'b0}}, field_i[NIB_W-1:0]};

  always_comb begin
    opnd_o = zext_w;
    wide_o = 1'b0;
    unique case (class_i)
      CLS_IDX_LOAD: begin opnd_o = flag_i ? ext_w : zext_w; wide_o = flag_i; end
      CLS_IDX_ADD:  begin opnd_o = flag_i ? ext_w : sext_w; wide_o = flag_i; end
      CLS_IDX_CMP:  begin opnd_o = flag_i ? inv_w : zext_w; wide_o = flag_i; end
      CLS_BR_REL:   begin opnd_o = flag_i ? ext_w : sext_w; wide_o = flag_i; end
      CLS_BR_A:     opnd_o = nib_w;
      default:      opnd_o = zext_w;
    endcase
  end
endmodule

// File: rtl/ext_br_adder.sv
module ext_br_adder #(
  parameter int WORD_W = 16,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] off_i,
  output logic [WORD_W-1:0] sum_o
);
  // sum = pc + off + 1, carry-in carries the +1
  generate
    if (RIPPLE) begin : g_ripple
      logic [WORD_W-1:0] c;
      assign c[0] = 1'b1;
      for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign sum_o[i] = pc_i[i] ^ off_i[i] ^ c[i];
        if (i < WORD_W - 1) begin : g_cy
          assign c[i+1] = (pc_i[i] & off_i[i]) | (c[i] & (pc_i[i] ^ off_i[i]));
        end
      end
    end else begin : g_behav
      assign sum_o = pc_i + off_i + WORD_W'(1);
    end
  endgenerate
endmodule

// File: rtl/ext_addr_unit.sv
module ext_addr_unit
  import ext_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  parameter bit RIPPLE = 1'b1,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pfx_load_i,
  input  logic [BYTE_W-1:0]  pfx_byte_i,
  input  logic               pfx_set_i,
  input  logic               ins_valid_i,
  input  logic [CLASS_W-1:0] ins_class_i,
  input  logic [BYTE_W-1:0]  ins_field_i,
  input  logic [WORD_W-1:0]  pc_i,
  output logic [WORD_W-1:0]  opnd_o,
  output logic [WORD_W-1:0]  target_o,
  output logic               wide_o,
  output logic               ext_flag_o
);
  logic              flag;
  logic [BYTE_W-1:0] ext_byte;
  logic [WORD_W-1:0] opnd, br_off, br_sum;
  logic              is_br;

  ext_state #(.BYTE_W(BYTE_W)) i_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (pfx_load_i),
    .byte_i   (pfx_byte_i),
    .set_i    (pfx_set_i),
    .consume_i(ins_valid_i),
    .flag_o   (flag),
    .ext_o    (ext_byte)
  );

  ext_widen #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) i_widen (
    .class_i(ins_class_i),
    .flag_i (flag),
    .ext_i  (ext_byte),
    .field_i(ins_field_i),
    .opnd_o (opnd),
    .wide_o (wide_o)
  );

  assign is_br  = class_is_branch(ins_class_i);
  assign br_off = is_br ? opnd : '0;

  ext_br_adder #(.WORD_W(WORD_W), .RIPPLE(RIPPLE)) i_adder (
    .pc_i (pc_i),
    .off_i(br_off),
    .sum_o(br_sum)
  );

  assign opnd_o     = opnd;
  assign target_o   = br_sum;
  assign ext_flag_o = flag;

  p_wide_needs_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_o |-> ext_flag_o);

  p_bra_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_class_i == CLS_BR_A) |->
      ((target_o - pc_i) >= WORD_W'(1) && (target_o - pc_i) <= WORD_W'(16)));

  p_seq_target_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !class_is_branch(ins_class_i) |-> (target_o == pc_i + WORD_W'(1)));
endmodule

// File: tb/test_ext_addr_unit.sv
module test_ext_addr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pfx_load_i = 1'b0, pfx_set_i = 1'b0, ins_valid_i = 1'b0;
  logic [7:0]  pfx_byte_i = '0, ins_field_i = '0;
  logic [2:0]  ins_class_i = '0;
  logic [15:0] pc_i = '0;
  logic [15:0] opnd_o, target_o;
  logic        wide_o, ext_flag_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_addr_unit i_ext_addr_unit (
    .clk_i(clk), .rst_ni(rst_ni), .pfx_load_i(pfx_load_i), .pfx_byte_i(pfx_byte_i),
    .pfx_set_i(pfx_set_i), .ins_valid_i(ins_valid_i), .ins_class_i(ins_class_i),
    .ins_field_i(ins_field_i), .pc_i(pc_i), .opnd_o(opnd_o), .target_o(target_o),
    .wide_o(wide_o), .ext_flag_o(ext_flag_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: apply inputs at negedge, settle, return before posedge
  task automatic apply(input bit ld, input logic [7:0] b, input bit st, input bit v,
                       input logic [2:0] c, input logic [7:0] f, input logic [15:0] pc);
    @(negedge clk);
    pfx_load_i = ld; pfx_byte_i = b; pfx_set_i = st;
    ins_valid_i = v; ins_class_i = c; ins_field_i = f; pc_i = pc;
    #1;
  endtask

  task automatic idle();
    apply(0, 8'h00, 0, 0, 3'd0, 8'h00, 16'h0000);
  endtask

  task automatic prefix(input logic [7:0] b);
    apply(1, b, 0, 0, 3'd0, 8'h00, 16'h0000);
  endtask

  task automatic t_reset();
    idle();
    chk("R1 flag", 16'(ext_flag_o), 16'h0);
    apply(0, 8'h00, 1, 0, 3'd0, 8'h00, 16'h0000);
    apply(0, 8'h00, 0, 1, 3'd1, 8'h3C, 16'h0000);
    chk("R1 byte", opnd_o, 16'h003C);
  endtask

  task automatic t_load_idx();
    prefix(8'h15);
    idle();
    chk("R2 flag", 16'(ext_flag_o), 16'h1);
    apply(0, 8'h00, 0, 1, 3'd1, 8'h7D, 16'h0000);
    chk("R3 ext", opnd_o, 16'h157D);
    chk("R11 wide", 16'(wide_o), 16'h1);
    apply(0, 8'h00, 0, 1, 3'd1, 8'h7D, 16'h0000);
    chk("R9 cleared", 16'(ext_flag_o), 16'h0);
    chk("R3 plain", opnd_o, 16'h007D);
  endtask

  task automatic t_add_idx();
    prefix(8'hB8);
    apply(0, 8'h00, 0, 1, 3'd2, 8'h4F, 16'h0000);
    chk("R4 ext", opnd_o, 16'hB84F);
    apply(0, 8'h00, 0, 1, 3'd2, 8'hF0, 16'h0000);
    chk("R4 sext", opnd_o, 16'hFFF0);
  endtask

  task automatic t_cmp();
    prefix(8'hE6);
    apply(0, 8'h00, 0, 1, 3'd3, 8'hA2, 16'h0000);
    chk("R5 ext", opnd_o, 16'h19A2);
    apply(0, 8'h00, 0, 1, 3'd3, 8'hA2, 16'h0000);
    chk("R5 plain", opnd_o, 16'h00A2);
  endtask

  task automatic t_br_rel();
    idle();
    apply(0, 8'h00, 0, 1, 3'd4, 8'h80, 16'h0100);
    chk("R6 back", target_o, 16'h0081);
    apply(0, 8'h00, 0, 1, 3'd4, 8'h7F, 16'h0100);
    chk("R6 fwd", target_o, 16'h0180);
    chk("R11 narrow", 16'(wide_o), 16'h0);
  endtask

  task automatic t_br_ext();
    prefix(8'hF0);
    apply(0, 8'h00, 0, 1, 3'd4, 8'h00, 16'h1000);
    chk("R7 back", target_o, 16'h0001);
    prefix(8'h7F);
    apply(0, 8'h00, 0, 1, 3'd4, 8'hFF, 16'h8000);
    chk("R7 wrap", target_o, 16'h0000);
  endtask

  task automatic t_br_a();
    idle();
    apply(0, 8'h00, 0, 1, 3'd5, 8'h0F, 16'h0FFF);
    chk("R8 max", target_o, 16'h100F);
    apply(0, 8'h00, 0, 1, 3'd5, 8'hF0, 16'h0FFF);
    chk("R8 min", target_o, 16'h1000);
    prefix(8'h55);
    apply(0, 8'h00, 0, 1, 3'd5, 8'h03, 16'h2000);
    chk("R8 flag ignored", target_o, 16'h2004);
    chk("R11 bra narrow", 16'(wide_o), 16'h0);
    idle();
    chk("R9 after bra", 16'(ext_flag_o), 16'h0);
  endtask

  task automatic t_reuse();
    prefix(8'h42);
    apply(0, 8'h00, 0, 1, 3'd0, 8'h11, 16'h0000);
    chk("R11 none opnd", opnd_o, 16'h0011);
    chk("R11 none tgt", target_o, 16'h0001);
    chk("R11 none narrow", 16'(wide_o), 16'h0);
    apply(0, 8'h00, 1, 0, 3'd0, 8'h00, 16'h0000);
    idle();
    chk("R10 flag", 16'(ext_flag_o), 16'h1);
    apply(0, 8'h00, 0, 1, 3'd1, 8'h99, 16'h0000);
    chk("R10 byte", opnd_o, 16'h4299);
  endtask

  task automatic t_hold();
    prefix(8'hA5);
    for (int i = 0; i < 4; i++) idle();
    chk("R12 flag", 16'(ext_flag_o), 16'h1);
    apply(0, 8'h00, 0, 1, 3'd6, 8'h22, 16'h0010);
    chk("R12 byte via none", opnd_o, 16'h0022);
    chk("R11 cls6 tgt", target_o, 16'h0011);
    apply(0, 8'h00, 0, 1, 3'd1, 8'h22, 16'h0000);
    chk("R9 cls6 consumed", opnd_o, 16'h0022);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    rst_ni = 1'b1;
    t_reset();
    t_load_idx();
    t_add_idx();
    t_cmp();
    t_br_rel();
    t_br_ext();
    t_br_a();
    t_reuse();
    t_hold();
    idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule